// File: doc/BRIEF.md
# Flat-Panel Power Sequencer

This block sequences the bring-up and shutdown of a flat-panel display. On a host request it switches on the panel supply and waits for a comparator to report that the rail has crossed its upper threshold. It then enables the video interface after a programmable delay, and lights the backlight once the interface has carried valid data long enough. When the request drops, it runs the same steps in reverse. After the rail has decayed below its lower threshold, it enforces a minimum dead time before any new power-up.

A millisecond strobe (`tick_ms`) drives every delay, and all windows are counted in whole strobes. A slow supply rise, or a collapse of the rail while the panel is powered, puts the sequencer into a fault state. In that state every enable is off, and the state is left only when the host withdraws its request. A sticky flag records that a fault has occurred.

Top module: `panel_pwr_seq`

## Requirements
- R1: After reset the supply, interface and backlight enables are low, `if_mode` is 2'b00 (tri-state), `ready` and `fault_flag` are low. Nothing starts while `pwr_req` is low. A high `pwr_req` in the idle state raises `supply_en`.
- R2: If `vdd_hi` has not been seen by the RISE_MS-th strobe after `supply_en` rose, the block enters FAULT on that strobe. In FAULT all enables are low, `if_mode` is 2'b01 (driven low) and `fault_flag` is set. When `vdd_hi` and the strobe arrive together, the rise counts as in time.
- R3: `data_en` rises exactly N strobes after the first cycle in which `vdd_hi` is seen with the supply on. N comes from `cfg_on_dly`: 0 selects DLY_DEF_MS, values above DLY_MAX_MS give DLY_MAX_MS, and any other value is used as is. `data_en` is never high without `supply_en`.
- R4: `bl_en` rises exactly BL_LEAD_MS strobes after `data_en` rose. `ready` is high only while the backlight is lit. `bl_en` never stands without `data_en`.
- R5: A low `pwr_req` while lit drops `bl_en` at once. `data_en` falls BL_LEAD_MS strobes later. `supply_en` falls a further N strobes later, where N comes from `cfg_off_dly` by the same rule as R3.
- R6: Once `vdd_lo` is seen after the supply has been removed, the block waits OFF_MS strobes before it can power up again. A request held high during that wait raises `supply_en` exactly OFF_MS strobes after `vdd_lo` was seen.
- R7: `if_mode` is 2'b10 (active) exactly while `data_en` is high. It is 2'b00 (tri-state) only during the idle and dead-time states, and never while `supply_en` is high. In every other state it is 2'b01 (driven low).
- R8: A low `pwr_req` during the rise or before the interface is enabled drops the supply directly, and `data_en` never rises. A low `pwr_req` while the interface is on but the backlight is not yet lit drops `data_en` at once, `bl_en` never rises, and the supply follows after the off delay.
- R9: `vdd_lo` seen while the supply is on and the rail has been qualified sends the block to FAULT and turns off all outputs. `fault_flag` stays set until reset.
- R10: FAULT holds all enables low for as long as `pwr_req` stays high. A low `pwr_req` leaves FAULT through the normal rail-decay and dead-time path.
- R11: A request raised again during power-down is ignored until the dead time has run. The backlight, data and supply steps finish with their normal timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_ms | input | 1 | One-cycle millisecond strobe |
| pwr_req | input | 1 | Host request: 1 = display on, 0 = display off |
| vdd_hi | input | 1 | Panel rail above 90 % |
| vdd_lo | input | 1 | Panel rail below 10 % |
| cfg_on_dly | input | CFG_W | Rail-valid to data-enable delay in ms (0 = default) |
| cfg_off_dly | input | CFG_W | Data-off to supply-off delay in ms (0 = default) |
| supply_en | output | 1 | Panel supply enable |
| data_en | output | 1 | Video interface enable |
| bl_en | output | 1 | Backlight enable |
| if_mode | output | 2 | Interface pin mode: 00 tri-state, 01 driven low, 10 active |
| ready | output | 1 | Display fully up |
| fault_flag | output | 1 | Sticky fault record |

## Verification
The bench keeps RISE_MS=10, DLY_DEF_MS=20 and DLY_MAX_MS=50. It shortens BL_LEAD_MS to 40 and OFF_MS to 100, so that more than twenty complete power cycles fit in a short run. The unchanged rise and delay limits still allow both clamp ends and the 10/11-strobe rise boundary to be hit. A behavioural rail model answers `supply_en` with a randomly slow or fast rise and decay. Each cycle, chosen at random, is a full cycle, an early withdrawal in one of two power-up states, a rail collapse, or a re-request during power-down. Every interval is measured in strobes at the ports and compared with the value the requirements give.

// File: rtl/pps_pkg.sv
package pps_pkg;

    typedef enum logic [3:0] {
        PS_IDLE,
        PS_REST,
        PS_RISE,
        PS_PRE_DATA,
        PS_DATA,
        PS_LIT,
        PS_DIM,
        PS_POST_DATA,
        PS_FALL,
        PS_FAULT
    } seq_state_e;

    typedef enum logic [1:0] {
        IFM_HIZ    = 2'b00,
        IFM_LOW    = 2'b01,
        IFM_ACTIVE = 2'b10
    } if_mode_e;

endpackage

// File: rtl/pps_tick_timer.sv
module pps_tick_timer #(
    parameter int CW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          tick,
    output logic [CW-1:0] count
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clear) begin
            cnt_d = '0;
        end else if (tick && (cnt_q != {CW{1'b1}})) begin
            cnt_d = cnt_q + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count = cnt_q;
endmodule

// File: rtl/pps_delay_sel.sv
module pps_delay_sel #(
    parameter int CFG_W = 6,
    parameter int DEF   = 20,
    parameter int MAX   = 50,
    parameter int CW    = 9
) (
    input  logic [CFG_W-1:0] cfg,
    output logic [CW-1:0]    limit
);
    always_comb begin
        if (cfg == '0) begin
            limit = CW'(DEF);
        end else if (int'(cfg) > MAX) begin
            limit = CW'(MAX);
        end else begin
            limit = CW'(cfg);
        end
    end
endmodule

// File: rtl/pps_out_decode.sv
module pps_out_decode
    import pps_pkg::*;
(
    input  seq_state_e st,
    output logic       supply_en,
    output logic       data_en,
    output logic       bl_en,
    output logic [1:0] if_mode,
    output logic       ready
);
    always_comb begin
        supply_en = 1'b0;
        data_en   = 1'b0;
        bl_en     = 1'b0;
        ready     = 1'b0;
        if_mode   = IFM_LOW;
        case (st)
            PS_IDLE, PS_REST: begin
                if_mode = IFM_HIZ;
            end
            PS_RISE, PS_PRE_DATA, PS_POST_DATA: begin
                supply_en = 1'b1;
            end
            PS_DATA, PS_DIM: begin
                supply_en = 1'b1;
                data_en   = 1'b1;
                if_mode   = IFM_ACTIVE;
            end
            PS_LIT: begin
                supply_en = 1'b1;
                data_en   = 1'b1;
                bl_en     = 1'b1;
                ready     = 1'b1;
                if_mode   = IFM_ACTIVE;
            end
            default: begin
                if_mode = IFM_LOW;
            end
        endcase
    end
endmodule

// File: rtl/panel_pwr_seq.sv
module panel_pwr_seq
    import pps_pkg::*;
#(
    parameter int CFG_W      = 6,
    parameter int RISE_MS    = 10,
    parameter int DLY_DEF_MS = 20,
    parameter int DLY_MAX_MS = 50,
    parameter int BL_LEAD_MS = 200,
    parameter int OFF_MS     = 500
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_ms,
    input  logic             pwr_req,
    input  logic             vdd_hi,
    input  logic             vdd_lo,
    input  logic [CFG_W-1:0] cfg_on_dly,
    input  logic [CFG_W-1:0] cfg_off_dly,
    output logic             supply_en,
    output logic             data_en,
    output logic             bl_en,
    output logic [1:0]       if_mode,
    output logic             ready,
    output logic             fault_flag
);
    localparam int MAX_A   = (RISE_MS > DLY_MAX_MS) ? RISE_MS : DLY_MAX_MS;
    localparam int MAX_B   = (BL_LEAD_MS > OFF_MS) ? BL_LEAD_MS : OFF_MS;
    localparam int LIM_MAX = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CW      = $clog2(LIM_MAX + 1);
    localparam int NSEL    = 2;

    typedef struct packed {
        seq_state_e st;
        logic       fault;
    } seq_reg_t;

    seq_reg_t      cur_q, nxt_d;
    logic [CW-1:0] cnt;
    logic [CW-1:0] lim;
    logic          expire;
    logic          timer_clr;

    // per-direction delay selection: index 0 power-up, index 1 power-down
    logic [CFG_W-1:0] cfg_arr [NSEL];
    logic [CW-1:0]    lim_arr [NSEL];

    assign cfg_arr[0] = cfg_on_dly;
    assign cfg_arr[1] = cfg_off_dly;

    generate
        for (genvar g = 0; g < NSEL; g++) begin : g_dsel
            pps_delay_sel #(
                .CFG_W (CFG_W),
                .DEF   (DLY_DEF_MS),
                .MAX   (DLY_MAX_MS),
                .CW    (CW)
            ) u_sel (
                .cfg   (cfg_arr[g]),
                .limit (lim_arr[g])
            );
        end
    endgenerate

    // window length of the current state
    always_comb begin
        case (cur_q.st)
            PS_RISE:      lim = CW'(RISE_MS);
            PS_PRE_DATA:  lim = lim_arr[0];
            PS_DATA:      lim = CW'(BL_LEAD_MS);
            PS_DIM:       lim = CW'(BL_LEAD_MS);
            PS_POST_DATA: lim = lim_arr[1];
            PS_REST:      lim = CW'(OFF_MS);
            default:      lim = CW'(LIM_MAX);
        endcase
    end

    assign expire = tick_ms && (cnt == (lim - CW'(1)));

    always_comb begin
        nxt_d = cur_q;
        case (cur_q.st)
            PS_IDLE: begin
                if (pwr_req) nxt_d.st = PS_RISE;
            end
            PS_REST: begin
                if (expire) nxt_d.st = PS_IDLE;
            end
            PS_RISE: begin
                if (!pwr_req) begin
                    nxt_d.st = PS_FALL;
                end else if (vdd_hi) begin
                    nxt_d.st = PS_PRE_DATA;
                end else if (expire) begin
                    nxt_d.st    = PS_FAULT;
                    nxt_d.fault = 1'b1;
                end
            end
            PS_PRE_DATA: begin
                if (vdd_lo) begin
                    nxt_d.st    = PS_FAULT;
                    nxt_d.fault = 1'b1;
                end else if (!pwr_req) begin
                    nxt_d.st = PS_FALL;
                end else if (expire) begin
                    nxt_d.st = PS_DATA;
                end
            end
            PS_DATA: begin
                if (vdd_lo) begin
                    nxt_d.st    = PS_FAULT;
                    nxt_d.fault = 1'b1;
                end else if (!pwr_req) begin
                    nxt_d.st = PS_POST_DATA;
                end else if (expire) begin
                    nxt_d.st = PS_LIT;
                end
            end
            PS_LIT: begin
                if (vdd_lo) begin
                    nxt_d.st    = PS_FAULT;
                    nxt_d.fault = 1'b1;
                end else if (!pwr_req) begin
                    nxt_d.st = PS_DIM;
                end
            end
            PS_DIM: begin
                if (vdd_lo) begin
                    nxt_d.st    = PS_FAULT;
                    nxt_d.fault = 1'b1;
                end else if (expire) begin
                    nxt_d.st = PS_POST_DATA;
                end
            end
            PS_POST_DATA: begin
                if (vdd_lo) begin
                    nxt_d.st    = PS_FAULT;
                    nxt_d.fault = 1'b1;
                end else if (expire) begin
                    nxt_d.st = PS_FALL;
                end
            end
            PS_FALL: begin
                if (vdd_lo) nxt_d.st = PS_REST;
            end
            PS_FAULT: begin
                if (!pwr_req) nxt_d.st = PS_FALL;
            end
            default: begin
                nxt_d.st = PS_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q.st    <= PS_IDLE;
            cur_q.fault <= 1'b0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign timer_clr = (nxt_d.st != cur_q.st);

    pps_tick_timer #(.CW(CW)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (timer_clr),
        .tick  (tick_ms),
        .count (cnt)
    );

    pps_out_decode u_dec (
        .st        (cur_q.st),
        .supply_en (supply_en),
        .data_en   (data_en),
        .bl_en     (bl_en),
        .if_mode   (if_mode),
        .ready     (ready)
    );

    assign fault_flag = cur_q.fault;
endmodule

// File: rtl/panel_pwr_seq_chk.sv
module panel_pwr_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       supply_en,
    input logic       data_en,
    input logic       bl_en,
    input logic [1:0] if_mode,
    input logic       ready,
    input logic       fault_flag
);
    assert_no_hiz_powered_R7: assert property (@(posedge clk) disable iff (!rst_n)
        supply_en |-> (if_mode != 2'b00));

    assert_data_needs_supply_R3: assert property (@(posedge clk) disable iff (!rst_n)
        data_en |-> supply_en);

    assert_bl_needs_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
        bl_en |-> (data_en && supply_en));

    assert_ready_only_lit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> bl_en);

    assert_bl_off_before_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(data_en) && supply_en) |-> $past(!bl_en));

    assert_fault_dark_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault_flag) |-> (!supply_en && !data_en && !bl_en));

    assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fault_flag |=> fault_flag);
endmodule

bind panel_pwr_seq panel_pwr_seq_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .supply_en  (supply_en),
    .data_en    (data_en),
    .bl_en      (bl_en),
    .if_mode    (if_mode),
    .ready      (ready),
    .fault_flag (fault_flag)
);

// File: tb/panel_pwr_seq_bench.sv
module panel_pwr_seq_bench;
    localparam int RISE  = 10;
    localparam int DDEF  = 20;
    localparam int DMAX  = 50;
    localparam int BL    = 40;
    localparam int OFFT  = 100;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       tick = 1'b0;
    logic       pwr_req = 1'b0;
    logic       vdd_hi = 1'b0;
    logic       vdd_lo = 1'b1;
    logic [5:0] cfg_on = '0;
    logic [5:0] cfg_off = '0;
    logic       supply_en, data_en, bl_en, ready, fault_flag;
    logic [1:0] if_mode;

    always #5 clk = ~clk;

    panel_pwr_seq #(
        .CFG_W(6), .RISE_MS(RISE), .DLY_DEF_MS(DDEF), .DLY_MAX_MS(DMAX),
        .BL_LEAD_MS(BL), .OFF_MS(OFFT)
    ) u_panel_pwr_seq (
        .clk(clk), .rst_n(rst_n), .tick_ms(tick), .pwr_req(pwr_req),
        .vdd_hi(vdd_hi), .vdd_lo(vdd_lo), .cfg_on_dly(cfg_on), .cfg_off_dly(cfg_off),
        .supply_en(supply_en), .data_en(data_en), .bl_en(bl_en),
        .if_mode(if_mode), .ready(ready), .fault_flag(fault_flag)
    );

    int n_chk = 0;
    int n_bad = 0;

    task automatic check(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int exp_dly(int cfg);
        if (cfg == 0) return DDEF;
        if (cfg > DMAX) return DMAX;
        return cfg;
    endfunction

    function automatic bit exp_fault(int r);
        return r > RISE;
    endfunction

    // strobe generator and rail model
    int  phase = 0;
    int  up_cnt = 0, dn_cnt = 0;
    int  rise_ticks = 3, fall_ticks = 3;
    bit  drop_now = 0;
    bit  model_on = 0;

    always @(negedge clk) begin
        phase = (phase + 1) % 4;
        tick  = (phase == 0);
        if (drop_now) begin
            vdd_hi = 1'b0;
            vdd_lo = 1'b1;
            if (!supply_en) begin
                drop_now = 0;
                model_on = 0;
            end
        end else if (supply_en && !model_on) begin
            model_on = 1;
            up_cnt   = 0;
            vdd_lo   = 1'b0;
            vdd_hi   = 1'b0;
        end else if (!supply_en && model_on) begin
            model_on = 0;
            dn_cnt   = 0;
            vdd_hi   = 1'b0;
        end
        if (model_on && !drop_now && tick && !vdd_hi) begin
            up_cnt++;
            if (up_cnt >= rise_ticks) vdd_hi = 1'b1;
        end
        if (!model_on && tick && !vdd_lo) begin
            dn_cnt++;
            if (dn_cnt >= fall_ticks) vdd_lo = 1'b1;
        end
    end

    // port monitor: strobe numbers of every edge
    int tickno = 0;
    int t_sr = 0, t_sf = 0, t_dr = 0, t_df = 0, t_br = 0, t_bf = 0, t_hi = 0, t_lo = 0;
    int n_dr = 0, n_br = 0;
    bit hi_done = 0, lo_armed = 0;

    always @(posedge clk) begin
        logic ps, pd, pb;
        if (tick) tickno++;
        if (supply_en && vdd_hi && !hi_done) begin
            hi_done = 1;
            t_hi    = tickno;
        end
        if (lo_armed && vdd_lo) begin
            lo_armed = 0;
            t_lo     = tickno;
        end
        ps = supply_en; pd = data_en; pb = bl_en;
        #1;
        if (supply_en && !ps) t_sr = tickno;
        if (!supply_en && ps) begin
            t_sf = tickno; hi_done = 0; lo_armed = 1;
        end
        if (data_en && !pd) begin t_dr = tickno; n_dr++; end
        if (!data_en && pd) t_df = tickno;
        if (bl_en && !pb) begin t_br = tickno; n_br++; end
        if (!bl_en && pb) t_bf = tickno;
    end

    task automatic wait_ticks(int n);
        repeat (n * 4) @(negedge clk);
    endtask

    // kind: 0 full, 1 off before data, 2 off before backlight, 3 rail collapse, 4 re-request in power-down
    task automatic power_cycle(int r, int con, int coff, int fall, int kind, bit chk_off,
                               output bit next_chk_off);
        int dr0, br0;
        rise_ticks = r;
        fall_ticks = fall;
        cfg_on     = 6'(con);
        cfg_off    = 6'(coff);
        pwr_req    = 1'b1;
        next_chk_off = 1'b1;
        wait (supply_en);
        @(negedge clk);
        if (chk_off) check("R6 dead time before power-up", t_sr - t_lo, OFFT);
        check("R7 driven low during rise", int'(if_mode), 1);
        if (exp_fault(r)) begin
            wait (!supply_en);
            @(negedge clk);
            check("R2 rise timeout strobes", t_sf - t_sr, RISE);
            check("R2 fault flag", int'(fault_flag), 1);
            check("R2 mode in fault", int'(if_mode), 1);
            wait_ticks(12);
            check("R10 fault holds with request high", int'(supply_en | data_en | bl_en), 0);
            pwr_req = 1'b0;
            wait_ticks(fall + 3);
            next_chk_off = 1'b0;
            return;
        end
        if (kind == 1) begin
            dr0 = n_dr;
            wait (hi_done);
            wait_ticks(2);
            pwr_req = 1'b0;
            wait (!supply_en);
            @(negedge clk);
            check("R8 no data on early withdrawal", n_dr - dr0, 0);
            wait (!lo_armed);
            return;
        end
        wait (data_en);
        @(negedge clk);
        check("R3 data-enable delay", t_dr - t_hi, exp_dly(con));
        check("R7 active mode with data", int'(if_mode), 2);
        if (kind == 2) begin
            br0 = n_br;
            wait_ticks(5);
            pwr_req = 1'b0;
            wait (!data_en);
            @(negedge clk);
            check("R8 data drops at once", t_df - t_dr, 5);
            check("R8 no backlight on withdrawal", n_br - br0, 0);
            wait (!supply_en);
            @(negedge clk);
            check("R8 supply-off delay", t_sf - t_df, exp_dly(coff));
            wait (!lo_armed);
            return;
        end
        wait (bl_en);
        @(negedge clk);
        check("R4 backlight lead", t_br - t_dr, BL);
        check("R4 ready while lit", int'(ready), 1);
        if (kind == 3) begin
            wait_ticks(3);
            drop_now = 1;
            wait (!supply_en);
            @(negedge clk);
            check("R9 rail collapse darkens", int'(data_en | bl_en | ready), 0);
            check("R9 fault flag on collapse", int'(fault_flag), 1);
            wait_ticks(8);
            check("R10 fault holds after collapse", int'(supply_en), 0);
            pwr_req = 1'b0;
            wait_ticks(3);
            next_chk_off = 1'b0;
            return;
        end
        wait_ticks(4);
        pwr_req = 1'b0;
        wait (!bl_en);
        @(negedge clk);
        check("R4 ready drops with backlight", int'(ready), 0);
        if (kind == 4) pwr_req = 1'b1;
        wait (!data_en);
        @(negedge clk);
        check("R5 backlight-to-data lead", t_df - t_bf, BL);
        wait (!supply_en);
        @(negedge clk);
        check("R5 supply-off delay", t_sf - t_df, exp_dly(coff));
        if (kind == 4) check("R11 power-down completes despite request", int'(supply_en), 0);
        wait (!lo_armed);
        @(negedge clk);
        check("R7 tri-state in dead time", int'(if_mode), 0);
        if (kind == 4) begin
            wait_ticks(OFFT / 2);
            check("R11 request held during dead time", int'(supply_en), 0);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        bit nco;
        bit cko;
        void'($urandom(32'h5eed_0042));
        rst_n = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset supply", int'(supply_en), 0);
        check("R1 reset data", int'(data_en), 0);
        check("R1 reset backlight", int'(bl_en), 0);
        check("R1 reset mode tri-state", int'(if_mode), 0);
        check("R1 reset ready", int'(ready), 0);
        check("R1 reset fault", int'(fault_flag), 0);
        wait_ticks(10);
        check("R1 idle without request", int'(supply_en), 0);

        // directed corners
        power_cycle(10, 0,  0,  5,  0, 1'b0, cko);   // rise on the last strobe, default delays
        power_cycle(4,  63, 51, 7,  0, cko,  cko);   // both delays clamped high
        power_cycle(2,  1,  1,  3,  4, cko,  cko);   // minimum delays, re-request in power-down
        power_cycle(11, 5,  5,  4,  0, cko,  cko);   // rise one strobe late
        power_cycle(3,  30, 9,  6,  1, cko,  cko);   // withdraw before data
        power_cycle(5,  12, 40, 8,  2, cko,  cko);   // withdraw before backlight
        power_cycle(6,  8,  8,  5,  3, cko,  cko);   // rail collapse while lit

        for (int i = 0; i < 16; i++) begin
            int r, con, coff, fl, kd;
            r    = 1 + int'($urandom % 12);
            con  = int'($urandom % 64);
            coff = int'($urandom % 64);
            fl   = 1 + int'($urandom % 20);
            kd   = int'($urandom % 5);
            if (kd == 1) con = 30;
            power_cycle(r, con, coff, fl, kd, cko, nco);
            cko = nco;
        end

        check("R9 fault flag remains set", int'(fault_flag), 1);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset clears fault flag", int'(fault_flag), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule